// File: doc/BRIEF.md
# Dual-Channel Register Access Decoder

This block is the host-bus front end of a two-channel serial controller. The host drives an active-low chip select, a channel select line, a three-bit register address, write data and active-low read and write strobes. The block turns each host access into a strobe for the register bank of one of the two channels. It forwards the latched address and write data to both banks, and it returns read data from the bank that was addressed. The host strobes are asynchronous to the block clock, so two flip-flops synchronize them. A small state machine then produces exactly one strobe per host cycle.

A one-bit broadcast control lives in the decoder itself. The host reaches it when the banks signal their alternate register page (`alt_page` high) and the address equals `CFG_ADDR`. While broadcast is set, one write cycle strobes the same register in both banks. Reads still come from the channel that the channel select line picks. Each bank keeps its own interrupt and DMA-request outputs, and these do not pass through this block.

The state machine has five states. IDLE waits for a synchronized strobe. WR_PULSE and RD_PULSE each last one cycle and issue the strobe. WR_HOLD and RD_HOLD wait for the host to release its strobe. The transitions are as follows:
- IDLE to WR_PULSE when the synchronized write strobe is low. Write wins if both strobes are low.
- IDLE to RD_PULSE when only the synchronized read strobe is low.
- WR_PULSE to WR_HOLD and RD_PULSE to RD_HOLD, unconditionally.
- WR_HOLD to IDLE and RD_HOLD to IDLE once the matching strobe is high again.

Chip select, channel select, page, address and data are captured on the transition out of IDLE.

Top module: `dual_reg_decoder`

## Requirements
- R1: After reset, no bank strobe is asserted and broadcast is off (the configuration register reads 0).
- R2: A host cycle during which `cs_n` is high produces no bank strobe and does not change broadcast.
- R3: With broadcast off, a write with `chan_sel`=1 strobes only bank A, and a write with `chan_sel`=0 strobes only bank B.
- R4: Each write cycle yields a write strobe exactly one clock long. It carries the address and data that the host presented.
- R5: With broadcast on, one write cycle strobes bank A and bank B in the same clock.
- R6: With broadcast on, a read still strobes and returns data from only the channel that `chan_sel` picks.
- R7: Each read cycle yields exactly one read strobe of one clock, to the selected bank only.
- R8: During a read, `rdata` equals `bank_rdata_a` when `chan_sel` was 1 and `bank_rdata_b` when it was 0.
- R9: A write with `alt_page`=1 and `addr`=`CFG_ADDR` (default 2) sets broadcast to `wdata` bit 0 and strobes no bank. A read of that location returns broadcast in bit 0 and zeros elsewhere, and strobes no bank.
- R10: Asserting reset after broadcast was set returns writes to single-channel routing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Host chip select, active low |
| chan_sel | input | 1 | 1 picks channel A, 0 picks channel B |
| alt_page | input | 1 | Banks are showing their alternate register page |
| addr | input | ADDR_W | Host register address |
| wr_n | input | 1 | Host write strobe, active low, asynchronous |
| rd_n | input | 1 | Host read strobe, active low, asynchronous |
| wdata | input | DATA_W | Host write data |
| rdata | output | DATA_W | Read data returned to the host |
| bank_rdata_a | input | DATA_W | Read data from bank A |
| bank_rdata_b | input | DATA_W | Read data from bank B |
| bank_addr | output | ADDR_W | Latched register address to both banks |
| bank_wdata | output | DATA_W | Latched write data to both banks |
| bank_alt | output | 1 | Latched page flag to both banks |
| bank_wr_a | output | 1 | One-clock write strobe, bank A |
| bank_wr_b | output | 1 | One-clock write strobe, bank B |
| bank_rd_a | output | 1 | One-clock read strobe, bank A |
| bank_rd_b | output | 1 | One-clock read strobe, bank B |

## Verification
Writes are tried with each `chan_sel` value, with broadcast off and on, and with chip select high. This separates single routing, dual routing and a suppressed cycle. Reads are repeated under the same conditions. This shows that broadcast never widens a read, that `rdata` tracks the chosen bank, and that only one strobe issues per host cycle however long the host holds its strobe. The configuration location is written and read back, and a reset follows, to show that the bit is held, that it never leaks a bank strobe, and that reset clears it.

// File: rtl/dual_reg_decoder_pkg.sv
package dual_reg_decoder_pkg;
    typedef enum logic [2:0] {
        S_IDLE     = 3'd0,
        S_WR_PULSE = 3'd1,
        S_WR_HOLD  = 3'd2,
        S_RD_PULSE = 3'd3,
        S_RD_HOLD  = 3'd4
    } acc_state_t;
endpackage

// File: rtl/drd_sync.sv
module drd_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] chain [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain[g] <= '1;
                end else begin
                    if (g == 0) chain[g] <= din;
                    else        chain[g] <= chain[(g > 0) ? g - 1 : 0];
                end
            end
        end
    endgenerate

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/drd_fsm.sv
module drd_fsm
    import dual_reg_decoder_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_low,
    input  logic rd_low,
    output logic capture,
    output logic wr_go,
    output logic rd_go
);
    acc_state_t state, nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt     = state;
        capture = 1'b0;
        wr_go   = 1'b0;
        rd_go   = 1'b0;
        unique case (state)
            S_IDLE: begin
                if (wr_low) begin
                    nxt     = S_WR_PULSE;
                    capture = 1'b1;
                end else if (rd_low) begin
                    nxt     = S_RD_PULSE;
                    capture = 1'b1;
                end
            end
            S_WR_PULSE: begin
                wr_go = 1'b1;
                nxt   = S_WR_HOLD;
            end
            S_WR_HOLD:  if (!wr_low) nxt = S_IDLE;
            S_RD_PULSE: begin
                rd_go = 1'b1;
                nxt   = S_RD_HOLD;
            end
            S_RD_HOLD:  if (!rd_low) nxt = S_IDLE;
            default:    nxt = S_IDLE;
        endcase
    end
endmodule

// File: rtl/drd_route.sv
module drd_route #(
    parameter int ADDR_W   = 3,
    parameter int DATA_W   = 8,
    parameter int CFG_ADDR = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic              wr_go,
    input  logic              rd_go,
    input  logic              cs_n,
    input  logic              chan_sel,
    input  logic              alt_page,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] bank_rdata_a,
    input  logic [DATA_W-1:0] bank_rdata_b,
    output logic [DATA_W-1:0] rdata,
    output logic [ADDR_W-1:0] bank_addr,
    output logic [DATA_W-1:0] bank_wdata,
    output logic              bank_alt,
    output logic              bank_wr_a,
    output logic              bank_wr_b,
    output logic              bank_rd_a,
    output logic              bank_rd_b
);
    localparam logic [ADDR_W-1:0] CFG_A = ADDR_W'(CFG_ADDR);

    logic sel_l, chan_l, bcast;
    logic cfg_hit, bank_wr, bank_rd;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_l      <= 1'b0;
            chan_l     <= 1'b0;
            bank_alt   <= 1'b0;
            bank_addr  <= '0;
            bank_wdata <= '0;
        end else if (capture) begin
            sel_l      <= ~cs_n;
            chan_l     <= chan_sel;
            bank_alt   <= alt_page;
            bank_addr  <= addr;
            bank_wdata <= wdata;
        end
    end

    assign cfg_hit = bank_alt && (bank_addr == CFG_A);
    assign bank_wr = wr_go && sel_l && !cfg_hit;
    assign bank_rd = rd_go && sel_l && !cfg_hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          bcast <= 1'b0;
        else if (wr_go && sel_l && cfg_hit)  bcast <= bank_wdata[0];
    end

    assign bank_wr_a = bank_wr && (chan_l || bcast);
    assign bank_wr_b = bank_wr && (!chan_l || bcast);
    assign bank_rd_a = bank_rd && chan_l;
    assign bank_rd_b = bank_rd && !chan_l;

    always_comb begin
        if (cfg_hit)     rdata = {{(DATA_W-1){1'b0}}, bcast};
        else if (chan_l) rdata = bank_rdata_a;
        else             rdata = bank_rdata_b;
    end
endmodule

// File: rtl/dual_reg_decoder.sv
module dual_reg_decoder #(
    parameter int ADDR_W      = 3,
    parameter int DATA_W      = 8,
    parameter int CFG_ADDR    = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              chan_sel,
    input  logic              alt_page,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_n,
    input  logic              rd_n,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic [DATA_W-1:0] bank_rdata_a,
    input  logic [DATA_W-1:0] bank_rdata_b,
    output logic [ADDR_W-1:0] bank_addr,
    output logic [DATA_W-1:0] bank_wdata,
    output logic              bank_alt,
    output logic              bank_wr_a,
    output logic              bank_wr_b,
    output logic              bank_rd_a,
    output logic              bank_rd_b
);
    logic [1:0] strobes_s;
    logic       capture, wr_go, rd_go;

    drd_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({wr_n, rd_n}),
        .dout  (strobes_s)
    );

    drd_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_low  (!strobes_s[1]),
        .rd_low  (!strobes_s[0]),
        .capture (capture),
        .wr_go   (wr_go),
        .rd_go   (rd_go)
    );

    drd_route #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CFG_ADDR(CFG_ADDR)) u_route (
        .clk          (clk),
        .rst_n        (rst_n),
        .capture      (capture),
        .wr_go        (wr_go),
        .rd_go        (rd_go),
        .cs_n         (cs_n),
        .chan_sel     (chan_sel),
        .alt_page     (alt_page),
        .addr         (addr),
        .wdata        (wdata),
        .bank_rdata_a (bank_rdata_a),
        .bank_rdata_b (bank_rdata_b),
        .rdata        (rdata),
        .bank_addr    (bank_addr),
        .bank_wdata   (bank_wdata),
        .bank_alt     (bank_alt),
        .bank_wr_a    (bank_wr_a),
        .bank_wr_b    (bank_wr_b),
        .bank_rd_a    (bank_rd_a),
        .bank_rd_b    (bank_rd_b)
    );
endmodule

// File: rtl/dual_reg_decoder_chk.sv
module dual_reg_decoder_chk (
    input logic clk,
    input logic rst_n,
    input logic cs_n,
    input logic chan_sel,
    input logic bank_wr_a,
    input logic bank_wr_b,
    input logic bank_rd_a,
    input logic bank_rd_b
);
    // R1: while reset is held, no strobe appears on the following edge
    a_r1_quiet_in_reset: assert property (@(posedge clk)
        !rst_n |=> !(bank_wr_a || bank_wr_b || bank_rd_a || bank_rd_b));

    // R2: any strobe traces back to chip select sampled low
    a_r2_needs_select: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_wr_a || bank_wr_b || bank_rd_a || bank_rd_b) |-> !$past(cs_n));

    // R3: a lone bank A write needs channel select high at capture
    a_r3_route_a: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_wr_a && !bank_wr_b) |-> $past(chan_sel));

    // R3: a lone bank B write needs channel select low at capture
    a_r3_route_b: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_wr_b && !bank_wr_a) |-> !$past(chan_sel));

    // R4: write strobes last one clock
    a_r4_wr_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_wr_a || bank_wr_b) |=> !(bank_wr_a || bank_wr_b));

    // R6 and R7: reads hit one bank only
    a_r7_rd_single: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({bank_rd_a, bank_rd_b}));

    // R7: read strobes last one clock
    a_r7_rd_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_rd_a || bank_rd_b) |=> !(bank_rd_a || bank_rd_b));

    // R6: a bank A read follows channel select high
    a_r6_rd_follows_sel: assert property (@(posedge clk) disable iff (!rst_n)
        bank_rd_a |-> $past(chan_sel));
endmodule

bind dual_reg_decoder dual_reg_decoder_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .chan_sel  (chan_sel),
    .bank_wr_a (bank_wr_a),
    .bank_wr_b (bank_wr_b),
    .bank_rd_a (bank_rd_a),
    .bank_rd_b (bank_rd_b)
);

// File: tb/dual_reg_decoder_tb.sv
module dual_reg_decoder_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1, chan_sel = 1'b0, alt_page = 1'b0;
    logic [2:0] addr = '0;
    logic       wr_n = 1'b1, rd_n = 1'b1;
    logic [7:0] wdata = '0, rdata, bank_wdata;
    logic [7:0] bank_rdata_a, bank_rdata_b;
    logic [2:0] bank_addr;
    logic       bank_alt, bank_wr_a, bank_wr_b, bank_rd_a, bank_rd_b;

    int total = 0, bad = 0;
    bit bc_model = 1'b0;
    logic [12:0] wq[$];
    logic [4:0]  rq[$];

    always #5 clk = ~clk;

    assign bank_rdata_a = {5'h14, bank_addr};
    assign bank_rdata_b = {5'h0B, bank_addr};

    dual_reg_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .chan_sel(chan_sel),
        .alt_page(alt_page), .addr(addr), .wr_n(wr_n), .rd_n(rd_n),
        .wdata(wdata), .rdata(rdata), .bank_rdata_a(bank_rdata_a),
        .bank_rdata_b(bank_rdata_b), .bank_addr(bank_addr),
        .bank_wdata(bank_wdata), .bank_alt(bank_alt),
        .bank_wr_a(bank_wr_a), .bank_wr_b(bank_wr_b),
        .bank_rd_a(bank_rd_a), .bank_rd_b(bank_rd_b)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor: each strobe cycle pops one expected item
    always @(negedge clk) begin
        if (rst_n && (bank_wr_a || bank_wr_b)) begin
            if (wq.size() == 0) check("R2/R4 unexpected write", {3'b0, bank_wr_a, bank_wr_b, bank_addr, bank_wdata}, 16'h0);
            else check("R3/R4/R5 write", {3'b0, bank_wr_a, bank_wr_b, bank_addr, bank_wdata}, {3'b0, wq.pop_front()});
        end
        if (rst_n && (bank_rd_a || bank_rd_b)) begin
            if (rq.size() == 0) check("R2/R7 unexpected read", {11'b0, bank_rd_a, bank_rd_b, bank_addr}, 16'h0);
            else check("R6/R7 read", {11'b0, bank_rd_a, bank_rd_b, bank_addr}, {11'b0, rq.pop_front()});
        end
    end

    task automatic do_write(input bit cs, input bit ch, input bit alt, input logic [2:0] a, input logic [7:0] d);
        bit cfg = alt && (a == 3'd2);
        if (!cs && !cfg) wq.push_back({ch || bc_model, !ch || bc_model, a, d});
        if (!cs && cfg) bc_model = d[0];
        @(negedge clk);
        cs_n = cs; chan_sel = ch; alt_page = alt; addr = a; wdata = d; wr_n = 1'b0;
        repeat (7) @(negedge clk);
        wr_n = 1'b1;
        repeat (4) @(negedge clk);
        cs_n = 1'b1;
    endtask

    task automatic do_read(input bit cs, input bit ch, input bit alt, input logic [2:0] a);
        bit cfg = alt && (a == 3'd2);
        logic [7:0] exp;
        if (!cs && !cfg) rq.push_back({ch, !ch, a});
        exp = cfg ? {7'b0, bc_model} : (ch ? {5'h14, a} : {5'h0B, a});
        @(negedge clk);
        cs_n = cs; chan_sel = ch; alt_page = alt; addr = a; rd_n = 1'b0;
        repeat (7) @(negedge clk);
        // R8 / R9: data returned while the host still holds its read strobe
        if (!cs) check(cfg ? "R9 cfg readback" : "R8 read data", {8'h0, rdata}, {8'h0, exp});
        rd_n = 1'b1;
        repeat (4) @(negedge clk);
        cs_n = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 strobes idle", {12'b0, bank_wr_a, bank_wr_b, bank_rd_a, bank_rd_b}, 16'h0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        do_read(1'b0, 1'b0, 1'b1, 3'd2);                  // R1 broadcast reads 0
        do_write(1'b0, 1'b1, 1'b0, 3'd3, 8'h5C);          // R3 channel A
        do_write(1'b0, 1'b0, 1'b0, 3'd7, 8'hE1);          // R3 channel B
        do_write(1'b1, 1'b1, 1'b0, 3'd1, 8'h77);          // R2 no select
        do_read (1'b1, 1'b0, 1'b0, 3'd4);                 // R2 no read strobe
        do_write(1'b1, 1'b0, 1'b1, 3'd2, 8'h01);          // R2 cfg untouched
        do_read(1'b0, 1'b1, 1'b1, 3'd2);                  // R2 still 0
        do_read(1'b0, 1'b1, 1'b0, 3'd5);                  // R7 R8 bank A
        do_read(1'b0, 1'b0, 1'b0, 3'd6);                  // R7 R8 bank B
        do_write(1'b0, 1'b1, 1'b1, 3'd2, 8'hFF);          // R9 set broadcast, no bank strobe
        do_read(1'b0, 1'b0, 1'b1, 3'd2);                  // R9 reads 1
        do_write(1'b0, 1'b1, 1'b0, 3'd0, 8'hA3);          // R5 both banks
        do_write(1'b0, 1'b0, 1'b1, 3'd4, 8'h3C);          // R5 both banks, alt page
        do_read(1'b0, 1'b1, 1'b0, 3'd1);                  // R6 only A
        do_read(1'b0, 1'b0, 1'b0, 3'd3);                  // R6 only B
        // R10: reset clears broadcast
        @(negedge clk); rst_n = 1'b0; bc_model = 1'b0;
        repeat (2) @(negedge clk); rst_n = 1'b1;
        repeat (2) @(negedge clk);
        do_write(1'b0, 1'b0, 1'b0, 3'd2, 8'h9D);          // R10 only B
        do_read(1'b0, 1'b1, 1'b1, 3'd2);                  // R10 reads 0
        repeat (3) @(negedge clk);
        check("R4 no missing writes", 16'(wq.size()), 16'h0);
        check("R7 no missing reads", 16'(rq.size()), 16'h0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #200000;
        total++; bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule